// File: doc/BRIEF.md
# Speculative Store Buffer With Load Forwarding

This block keeps the results of stores that have executed but are not yet retired, so that memory changes only after a store is known to be on the correct path. Each slot holds a word address, a 32-bit data word, a sequence tag giving the store's age, a live bit and a speculative bit. Executing a store claims a free slot and marks it live and speculative. Retiring the store clears its speculative bit. Squashing the store kills the slot. Retired slots are written out to the data cache, oldest first, over a valid/ready handshake. A slot becomes free again in the cycle after its write-out is accepted.

Loads look in the buffer before they use the cache. A load supplies its word address and its own sequence tag. The buffer returns the data of the youngest live store to the same address that is older than the load. If no such store exists, the word the cache returned for that load passes through unchanged.

Ages are sequence tags that wrap around. Tag `a` is older than tag `b` when `(a - b)` modulo 2^SEQW has its top bit set. All tags in flight must therefore lie within half the tag space of each other. When all slots are live, an incoming store is refused with a stall.

Top module: `spec_store_buf`

## Requirements
- R1: While reset is held, and after it is released, no slot is live: `dr_valid`=0, `ld_hit`=0, `st_stall`=0 and `ld_data` equals `cache_rdata`.
- R2: A store presented with `st_valid`=1 while a slot is free is written in that clock edge as live and speculative, with its address, data and tag. Loads see it from the next cycle on.
- R3: A load forwards from the youngest live slot whose address equals `ld_addr` exactly and whose tag is strictly older than `ld_seq`. It then drives `ld_hit`=1 and `ld_data` = that slot's data. A slot with an equal or younger tag is ignored.
- R4: With no forwarding slot, `ld_hit`=0 and `ld_data` = `cache_rdata`, the same cycle.
- R5: Age is wrap-aware: tag `a` is older than `b` when bit SEQW-1 of `(a - b)` mod 2^SEQW is 1. With SEQW=5, tag 30 is older than tags 31, 0 and 2, and tag 1 is younger than 31.
- R6: `cm_valid` with tag `cm_seq` clears the speculative bit of the live speculative slot holding that tag. The slot stays visible to loads until it is written out. Retirements arrive in program order.
- R7: `ab_valid` with tag `ab_seq` kills the live speculative slot holding that tag. A retired slot with that tag is not affected.
- R8: `dr_valid` is 1 exactly when a retired live slot exists. `dr_addr`/`dr_data` show the oldest retired slot and hold stable while `dr_ready` is 0.
- R9: A write-out is accepted on an edge with `dr_valid`=1 and `dr_ready`=1. The slot is free from the next cycle on, and loads no longer see it. A speculative slot is never written out.
- R10: With all slots live, `st_stall` = `st_valid` and the store is dropped. A slot freed by a write-out can be claimed from the cycle after acceptance, not in the acceptance cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| st_valid | input | 1 | Store execute request |
| st_addr | input | AW | Word-aligned store address |
| st_data | input | DW | Store data |
| st_seq | input | SEQW | Store sequence tag |
| st_stall | output | 1 | Store refused, all slots live |
| cm_valid | input | 1 | Retire a store |
| cm_seq | input | SEQW | Tag of the retiring store |
| ab_valid | input | 1 | Squash a store |
| ab_seq | input | SEQW | Tag of the squashed store |
| ld_addr | input | AW | Load word address |
| ld_seq | input | SEQW | Load sequence tag |
| cache_rdata | input | DW | Word read from the cache for this load |
| ld_hit | output | 1 | Load data taken from the buffer |
| ld_data | output | DW | Load result |
| dr_valid | output | 1 | Write-out to the cache pending |
| dr_addr | output | AW | Write-out address |
| dr_data | output | DW | Write-out data |
| dr_ready | input | 1 | Cache accepts the write-out |

## Verification
Loads are tried against a fixed population of four stores, three of them to one address with interleaved tags. For each load tag, the expected source is a different store or the cache, so a wrong choice among several matches shows up as a wrong data word. A second population straddles the tag wrap point, which separates a wrap-aware age compare from a plain magnitude compare. Further sequences squash a speculative slot and a retired one, hold the write-out with ready low, and fill every slot. These show whether a squash reaches retired data, whether write-out order follows age, and in which cycle a freed slot can be claimed again.

// File: rtl/ssb_pkg.sv
package ssb_pkg;
  localparam int SSB_ENTRIES = 8;
  localparam int SSB_AW      = 32;
  localparam int SSB_DW      = 32;
  localparam int SSB_SEQW    = 5;

  typedef struct packed {
    logic live;
    logic spec;
  } ssb_flags_t;
endpackage

// File: rtl/ssb_free_find.sv
module ssb_free_find #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  live,
  output logic          any_free,
  output logic [IW-1:0] free_idx
);
  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!live[i]) begin
        any_free = 1'b1;
        free_idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/ssb_age_pick.sv
module ssb_age_pick #(
  parameter int N        = 8,
  parameter int SEQW     = 5,
  parameter bit YOUNGEST = 1'b1,
  parameter int IW       = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    cand,
  input  logic [N*SEQW-1:0] seq_flat,
  output logic            any,
  output logic [IW-1:0]   idx
);
  function automatic logic precedes(input logic [SEQW-1:0] a, input logic [SEQW-1:0] b);
    logic [SEQW-1:0] d;
    d = a - b;
    return d[SEQW-1];
  endfunction

  logic [SEQW-1:0] best;

  always_comb begin
    logic [SEQW-1:0] s;
    logic            win;
    any  = 1'b0;
    idx  = '0;
    best = '0;
    for (int i = 0; i < N; i++) begin
      s   = seq_flat[i*SEQW +: SEQW];
      win = YOUNGEST ? precedes(best, s) : precedes(s, best);
      if (cand[i] && (!any || win)) begin
        any  = 1'b1;
        idx  = IW'(i);
        best = s;
      end
    end
  end

  AST_PICK_IS_CAND: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> cand[idx]);  // R3

  for (genvar g = 0; g < N; g++) begin : g_chk
    AST_CAND_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
      cand[g] |-> any);  // R8
  end
endmodule

// File: rtl/spec_store_buf.sv
module spec_store_buf
  import ssb_pkg::*;
#(
  parameter int ENTRIES = SSB_ENTRIES,
  parameter int AW      = SSB_AW,
  parameter int DW      = SSB_DW,
  parameter int SEQW    = SSB_SEQW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            st_valid,
  input  logic [AW-1:0]   st_addr,
  input  logic [DW-1:0]   st_data,
  input  logic [SEQW-1:0] st_seq,
  output logic            st_stall,
  input  logic            cm_valid,
  input  logic [SEQW-1:0] cm_seq,
  input  logic            ab_valid,
  input  logic [SEQW-1:0] ab_seq,
  input  logic [AW-1:0]   ld_addr,
  input  logic [SEQW-1:0] ld_seq,
  input  logic [DW-1:0]   cache_rdata,
  output logic            ld_hit,
  output logic [DW-1:0]   ld_data,
  output logic            dr_valid,
  output logic [AW-1:0]   dr_addr,
  output logic [DW-1:0]   dr_data,
  input  logic            dr_ready
);
  localparam int IW = $clog2(ENTRIES);

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  // slot state
  ssb_flags_t            flags_q [ENTRIES];
  ssb_flags_t            flags_d [ENTRIES];
  logic [AW-1:0]         addr_q  [ENTRIES];
  logic [DW-1:0]         data_q  [ENTRIES];
  logic [SEQW-1:0]       seq_q   [ENTRIES];

  logic [ENTRIES-1:0]      live_vec, fwd_cand, drn_cand;
  logic [ENTRIES-1:0]      ent_we, cm_hit, ab_hit, drn_clr;
  logic [ENTRIES*SEQW-1:0] seq_flat;
  logic                    any_free, fwd_any, drn_any;
  logic [IW-1:0]           free_idx, fwd_idx, drn_idx;
  logic                    st_fire, dr_fire;

  function automatic logic older(input logic [SEQW-1:0] a, input logic [SEQW-1:0] b);
    logic [SEQW-1:0] d;
    d = a - b;
    return d[SEQW-1];
  endfunction

  assign st_fire  = st_valid && any_free;
  assign st_stall = st_valid && !any_free;
  assign dr_fire  = drn_any && dr_ready;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign live_vec[g] = flags_q[g].live;
    assign seq_flat[g*SEQW +: SEQW] = seq_q[g];
    assign fwd_cand[g] = flags_q[g].live && (addr_q[g] == ld_addr) && older(seq_q[g], ld_seq);
    assign drn_cand[g] = flags_q[g].live && !flags_q[g].spec;
    assign ent_we[g]   = st_fire && (free_idx == IW'(g));
    assign cm_hit[g]   = cm_valid && flags_q[g].live && flags_q[g].spec && (seq_q[g] == cm_seq);
    assign ab_hit[g]   = ab_valid && flags_q[g].live && flags_q[g].spec && (seq_q[g] == ab_seq);
    assign drn_clr[g]  = dr_fire && (drn_idx == IW'(g));

    always_comb begin
      flags_d[g] = flags_q[g];
      if (cm_hit[g])  flags_d[g].spec = 1'b0;
      if (ab_hit[g])  flags_d[g].live = 1'b0;
      if (drn_clr[g]) flags_d[g].live = 1'b0;
      if (ent_we[g])  flags_d[g] = '{live: 1'b1, spec: 1'b1};
    end

    always_ff @(posedge clk or negedge rst_i_n) begin
      if (!rst_i_n) flags_q[g] <= '{live: 1'b0, spec: 1'b0};
      else          flags_q[g] <= flags_d[g];
    end

    always_ff @(posedge clk) begin
      if (ent_we[g]) begin
        addr_q[g] <= st_addr;
        data_q[g] <= st_data;
        seq_q[g]  <= st_seq;
      end
    end

    AST_RETIRED_KEPT: assert property (@(posedge clk) disable iff (!rst_i_n)
      (flags_q[g].live && !flags_q[g].spec && !drn_clr[g]) |=> (flags_q[g].live && !flags_q[g].spec));  // R7
  end

  ssb_free_find #(.N(ENTRIES), .IW(IW)) u_free (
    .live     (live_vec),
    .any_free (any_free),
    .free_idx (free_idx)
  );

  ssb_age_pick #(.N(ENTRIES), .SEQW(SEQW), .YOUNGEST(1'b1), .IW(IW)) u_fwd (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .cand     (fwd_cand),
    .seq_flat (seq_flat),
    .any      (fwd_any),
    .idx      (fwd_idx)
  );

  ssb_age_pick #(.N(ENTRIES), .SEQW(SEQW), .YOUNGEST(1'b0), .IW(IW)) u_drn (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .cand     (drn_cand),
    .seq_flat (seq_flat),
    .any      (drn_any),
    .idx      (drn_idx)
  );

  assign ld_hit   = fwd_any;
  assign ld_data  = fwd_any ? data_q[fwd_idx] : cache_rdata;
  assign dr_valid = drn_any;
  assign dr_addr  = addr_q[drn_idx];
  assign dr_data  = data_q[drn_idx];

  AST_STORE_FILLS: assert property (@(posedge clk) disable iff (!rst_i_n)
    (st_valid && !st_stall && !ab_valid && !dr_fire)
      |=> ($countones(live_vec) == $past($countones(live_vec)) + 1));  // R2

  AST_STALL_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_i_n)
    (st_stall && !ab_valid && !dr_fire) |=> ($countones(live_vec) == ENTRIES));  // R10

  AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_i_n)
    (dr_valid && !dr_ready) |=> (dr_valid && $stable(dr_addr) && $stable(dr_data)));  // R8
endmodule

// File: tb/sim_spec_store_buf.sv
module sim_spec_store_buf;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        st_valid, cm_valid, ab_valid, dr_ready;
  logic [31:0] st_addr, st_data, ld_addr, cache_rdata;
  logic [4:0]  st_seq, cm_seq, ab_seq, ld_seq;
  logic        st_stall, ld_hit, dr_valid;
  logic [31:0] ld_data, dr_addr, dr_data;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  spec_store_buf u0 (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_seq(st_seq), .st_stall(st_stall),
    .cm_valid(cm_valid), .cm_seq(cm_seq), .ab_valid(ab_valid), .ab_seq(ab_seq),
    .ld_addr(ld_addr), .ld_seq(ld_seq), .cache_rdata(cache_rdata), .ld_hit(ld_hit), .ld_data(ld_data),
    .dr_valid(dr_valid), .dr_addr(dr_addr), .dr_data(dr_data), .dr_ready(dr_ready)
  );

  // {addr, load seq, expected hit, expected data}; cache word is 32'hCAC0_0000
  localparam logic [69:0] LD_TAB [8] = '{
    {32'h100, 5'd2, 1'b1, 32'hA1},
    {32'h100, 5'd4, 1'b1, 32'hA3},
    {32'h100, 5'd8, 1'b1, 32'hA7},
    {32'h100, 5'd7, 1'b1, 32'hA3},
    {32'h100, 5'd1, 1'b0, 32'hCAC0_0000},
    {32'h200, 5'd6, 1'b1, 32'hB5},
    {32'h200, 5'd5, 1'b0, 32'hCAC0_0000},
    {32'h300, 5'd9, 1'b0, 32'hCAC0_0000}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic store(input logic [31:0] a, input logic [31:0] d, input logic [4:0] s);
    st_valid = 1'b1; st_addr = a; st_data = d; st_seq = s;
    tick();
    st_valid = 1'b0;
  endtask

  task automatic retire(input logic [4:0] s);
    cm_valid = 1'b1; cm_seq = s;
    tick();
    cm_valid = 1'b0;
  endtask

  task automatic squash(input logic [4:0] s);
    ab_valid = 1'b1; ab_seq = s;
    tick();
    ab_valid = 1'b0;
  endtask

  task automatic load(input string req, input logic [31:0] a, input logic [4:0] s,
                      input logic eh, input logic [31:0] ed);
    ld_addr = a; ld_seq = s; cache_rdata = 32'hCAC0_0000;
    #1;
    chk(req, {31'd0, ld_hit}, {31'd0, eh});
    chk(req, ld_data, ed);
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) tick();
  endtask

  initial begin
    st_valid = 0; cm_valid = 0; ab_valid = 0; dr_ready = 0;
    st_addr = 0; st_data = 0; st_seq = 0; cm_seq = 0; ab_seq = 0;
    ld_addr = 32'h100; ld_seq = 0; cache_rdata = 32'hCAC0_0000;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    // R1: state while reset is held
    chk("R1 dr_valid in reset", {31'd0, dr_valid}, 32'd0);
    chk("R1 ld_data in reset", ld_data, 32'hCAC0_0000);
    do_reset();
    chk("R1 stall after reset", {31'd0, st_stall}, 32'd0);
    load("R1 empty load", 32'h100, 5'd3, 1'b0, 32'hCAC0_0000);

    // R2: populate, visible next cycle
    store(32'h100, 32'hA1, 5'd1);
    load("R2 first store visible", 32'h100, 5'd2, 1'b1, 32'hA1);
    store(32'h100, 32'hA3, 5'd3);
    store(32'h200, 32'hB5, 5'd5);
    store(32'h100, 32'hA7, 5'd7);
    chk("R6 no drain while speculative", {31'd0, dr_valid}, 32'd0);

    // R3/R4: table walk
    for (int i = 0; i < 8; i++) begin
      load(LD_TAB[i][0] ? "R3 forward" : "R4 cache",
           LD_TAB[i][69:38], LD_TAB[i][37:33], LD_TAB[i][32], LD_TAB[i][31:0]);
    end

    // R6: retire in order, still visible
    retire(5'd1);
    retire(5'd3);
    load("R6 retired still forwards", 32'h100, 5'd2, 1'b1, 32'hA1);
    chk("R8 oldest retired addr", dr_addr, 32'h100);
    chk("R8 oldest retired data", dr_data, 32'hA1);
    tick();
    chk("R8 hold while not ready", dr_data, 32'hA1);

    // R7: squash speculative and retired
    squash(5'd7);
    load("R7 squashed slot gone", 32'h100, 5'd8, 1'b1, 32'hA3);
    squash(5'd1);
    load("R7 retired slot survives squash", 32'h100, 5'd2, 1'b1, 32'hA1);

    // R8/R9: write-out order and freeing
    dr_ready = 1'b1;
    tick();
    dr_ready = 1'b0;
    chk("R8 next oldest data", dr_data, 32'hA3);
    load("R9 drained slot not forwarded", 32'h100, 5'd2, 1'b0, 32'hCAC0_0000);
    dr_ready = 1'b1;
    tick();
    dr_ready = 1'b0;
    chk("R9 speculative not written out", {31'd0, dr_valid}, 32'd0);
    retire(5'd5);
    chk("R8 valid after retire", {31'd0, dr_valid}, 32'd1);
    chk("R8 addr after retire", dr_addr, 32'h200);
    dr_ready = 1'b1;
    tick();
    dr_ready = 1'b0;

    // R5: wrap-aware age
    store(32'h500, 32'h0000_0E1E, 5'd30);
    store(32'h500, 32'h0000_0E01, 5'd1);
    load("R5 30 older than 31, 1 younger", 32'h500, 5'd31, 1'b1, 32'h0E1E);
    load("R5 30 older than 0", 32'h500, 5'd0, 1'b1, 32'h0E1E);
    load("R5 1 older than 2", 32'h500, 5'd2, 1'b1, 32'h0E01);

    // R10: full buffer
    do_reset();
    for (int i = 0; i < 8; i++) store(32'h1000 + 32'(i * 4), 32'hD0 + 32'(i), 5'(i));
    st_valid = 1'b1; st_addr = 32'h3000; st_data = 32'hBAD; st_seq = 5'd8;
    #1;
    chk("R10 stall when full", {31'd0, st_stall}, 32'd1);
    tick();
    st_valid = 1'b0;
    retire(5'd0);
    load("R10 dropped store absent", 32'h3000, 5'd9, 1'b0, 32'hCAC0_0000);
    st_valid = 1'b1; st_addr = 32'h2000; st_data = 32'hEE; st_seq = 5'd8;
    dr_ready = 1'b1;
    #1;
    chk("R10 still stalled in accept cycle", {31'd0, st_stall}, 32'd1);
    tick();
    dr_ready = 1'b0;
    chk("R10 freed slot claimable", {31'd0, st_stall}, 32'd0);
    tick();
    st_valid = 1'b0;
    load("R10 new store written", 32'h2000, 5'd9, 1'b1, 32'hEE);
    load("R9 freed slot gone", 32'h1000, 5'd9, 1'b0, 32'hCAC0_0000);

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired got running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule